// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block is the protocol layer of an SMBus target. A byte-level I2C target engine below it reports bus activity as single-cycle strobes: start for write, start for read, stop, master NACK, received byte, and request for a byte to transmit. From these strobes the decoder works out which transaction the host ran. It can be a quick command, a send byte, a receive byte, a command write or a command read. It then hands the result to a register back end through single-cycle request outputs.

The transaction type is not known when the transaction starts. It follows from how many bytes were written before the stop or the repeated start. Written bytes are therefore collected in a small buffer. The first buffered byte serves as the command. The remaining buffered bytes form the write payload. A fault state absorbs any event that is illegal in the current state, and only a stop clears it. The back end answers a byte request combinationally in the same cycle.

Top module: `smbus_txn_decoder`

## Requirements
- R1: After reset the block is idle. The outputs `fault`, `overflow`, `quick_pulse`, `send_pulse`, `wr_pulse`, `rx_req` and `rd_req` are all 0.
- R2: A write-start in idle opens a write phase and clears `overflow`. A write-start in any other state enters the fault state. `fault` is 1 from the cycle after the event.
- R3: The result of a stop depends on the state.
  - In a write phase with no bytes buffered, `quick_pulse` is 1 in the next cycle with `quick_rd`=0.
  - After a read-start from idle, `quick_pulse` is 1 in the next cycle with `quick_rd`=1.
- R4: A stop in a write phase with exactly one byte buffered gives `send_pulse`=1 in the next cycle, with `cmd` equal to that byte.
- R5: A stop in a write phase with n≥2 bytes buffered gives `wr_pulse`=1 in the next cycle, with the following values:
  - `cmd` is the first byte.
  - `wr_len` is n−1.
  - Payload byte k, at `wr_payload[8k+7:8k]`, is the (k+2)-th byte received.
- R6: A read-start in a write phase has three outcomes:
  - With no bytes buffered, it enters the fault state.
  - With one byte buffered, it keeps that byte as `cmd`, issues no request, and enters the read phase.
  - With n≥2 bytes buffered, it first issues the write exactly as in R5 and then enters the read phase.
  In both non-fault cases the byte index restarts at 0.
- R7: A byte request in the receive-byte state (after a read-start from idle) raises `rx_req` in the same cycle and drives `tx_byte`=`be_rdata`. After that the state is done, so a second request enters the fault state.
- R8: A byte request in the read phase raises `rd_req` in the same cycle and drives `tx_byte`=`be_rdata`. `rd_idx` gives the index, which then increments, wrapping modulo 2^IDX_W.
- R9: NACK handling depends on the state:
  - A NACK in the read phase moves to done.
  - A NACK in done has no effect; `fault` stays 0.
  - A NACK in any other state enters the fault state.
- R10: A received byte is stored only during a write phase. In every other state it is ignored, and `cmd` is unchanged.
- R11: The buffer holds DEPTH (34) bytes. Further bytes are dropped and set `overflow`. `overflow` stays 1 until the next write-start accepted in idle. A write of DEPTH or more bytes reports `wr_len`=DEPTH−1.
- R12: A byte request in the idle, write-phase, done or fault state drives `tx_byte`=0x00, raises neither request, and enters the fault state. Every event except a stop leaves the fault state unchanged. A stop from any state returns to idle and clears the byte count.
- R13: Strobes that coincide in one cycle are resolved by priority. Only the winner acts. The order, highest first, is stop, write-start, read-start, NACK, byte request, received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wstart | input | 1 | Start (or repeated start) addressed for write |
| ev_rstart | input | 1 | Start (or repeated start) addressed for read |
| ev_stop | input | 1 | Stop / end of transfer |
| ev_nack | input | 1 | Master NACKed the last byte sent |
| ev_rx | input | 1 | A byte was received from the master |
| rx_byte | input | 8 | Received byte, valid with ev_rx |
| ev_rdreq | input | 1 | Engine needs a byte to transmit |
| be_rdata | input | 8 | Back-end answer to rx_req / rd_req, same cycle |
| tx_byte | output | 8 | Byte returned to the engine for ev_rdreq |
| quick_pulse | output | 1 | Quick command issued |
| quick_rd | output | 1 | Quick command direction (1 = read), valid with quick_pulse |
| send_pulse | output | 1 | Send-byte issued; the byte is on cmd |
| wr_pulse | output | 1 | Command write issued |
| wr_len | output | $clog2(DEPTH) | Payload byte count, valid with wr_pulse |
| wr_payload | output | 8*(DEPTH-1) | Payload bytes, byte k at bits 8k+7:8k |
| cmd | output | 8 | First buffered byte (command or send-byte data) |
| rx_req | output | 1 | Receive-byte request to the back end |
| rd_req | output | 1 | Command-read request to the back end |
| rd_idx | output | IDX_W | Byte index of the read request |
| overflow | output | 1 | Sticky: bytes beyond DEPTH were dropped |
| fault | output | 1 | Block is in the fault state |

## Verification
Two functions can fall in the same cycle. A repeated start for read after two or more written bytes both issues the buffered write request and opens the read phase with its index reset. The bench provokes this, then checks the write pulse, length and payload on the following cycle and the first read request at index 0. Coincident strobes are a second case: the bench drives pairs such as write-start with a data byte, stop with a byte request, and NACK with a byte request. The model judges each pair by the stated priority, so that only the winning strobe has an effect at the outputs. A long pseudo-random strobe sequence then mixes single and paired events against the same per-clock model.

// File: rtl/smbt_pkg.sv
`timescale 1ns/1ps
package smbt_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WDATA  = 3'd1,
    S_RXBYTE = 3'd2,
    S_RDATA  = 3'd3,
    S_DONE   = 3'd4,
    S_FAULT  = 3'd5
  } st_t;

  typedef enum logic [1:0] {
    X_NONE  = 2'd0,
    X_QUICK = 2'd1,
    X_SEND  = 2'd2,
    X_WRITE = 2'd3
  } act_t;

  // Action taken when a write phase ends with a stop.
  function automatic act_t flush_action(input int nbytes);
    if (nbytes == 0) return X_QUICK;
    if (nbytes == 1) return X_SEND;
    return X_WRITE;
  endfunction

  // Action taken when a write phase ends with a repeated start for read.
  function automatic act_t turn_action(input int nbytes);
    return (nbytes > 1) ? X_WRITE : X_NONE;
  endfunction

endpackage

// File: rtl/smbt_buf.sv
`timescale 1ns/1ps
module smbt_buf #(
  parameter int DEPTH = 34,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   append,
  input  logic                   cnt_clr,
  input  logic                   idx_inc,
  input  logic                   ovf_clr,
  input  logic [7:0]             rx_byte,
  output logic [IDX_W-1:0]       cnt,
  output logic                   overflow,
  output logic [7:0]             cmd,
  output logic [8*(DEPTH-1)-1:0] payload
);

  logic [8*DEPTH-1:0] bytes_q;
  logic               room;

  assign room = (cnt < IDX_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (append && cnt == IDX_W'(k)) bytes_q[8*k +: 8] <= rx_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (cnt_clr)            cnt <= '0;
    else if (append && room)     cnt <= cnt + 1'b1;
    else if (idx_inc)            cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  overflow <= 1'b0;
    else if (ovf_clr)            overflow <= 1'b0;
    else if (append && !room)    overflow <= 1'b1;
  end

  assign cmd = bytes_q[7:0];

  for (genvar k = 0; k < DEPTH-1; k++) begin : g_pay
    assign payload[8*k +: 8] = bytes_q[8*(k+1) +: 8];
  end

endmodule

// File: rtl/smbt_fsm.sv
`timescale 1ns/1ps
module smbt_fsm
  import smbt_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_wstart,
  input  logic             ev_rstart,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             ev_rx,
  input  logic             ev_rdreq,
  input  logic [IDX_W-1:0] cnt,
  input  logic [7:0]       be_rdata,
  output st_t              st,
  output logic             e_ws,
  output logic             e_stop,
  output logic             append,
  output logic             cnt_clr,
  output logic             idx_inc,
  output logic             ovf_clr,
  output logic [7:0]       tx_byte,
  output logic             rx_req,
  output logic             rd_req,
  output logic             quick_pulse,
  output logic             quick_rd,
  output logic             send_pulse,
  output logic             wr_pulse,
  output logic [LEN_W-1:0] wr_len
);

  logic e_rs, e_nk, e_rq, e_rx;
  st_t  st_nx;
  act_t act;
  logic act_rd;

  // Priority resolution of coincident strobes.
  assign e_stop = ev_stop;
  assign e_ws   = ev_wstart & ~ev_stop;
  assign e_rs   = ev_rstart & ~ev_stop & ~ev_wstart;
  assign e_nk   = ev_nack   & ~(ev_stop | ev_wstart | ev_rstart);
  assign e_rq   = ev_rdreq  & ~(ev_stop | ev_wstart | ev_rstart | ev_nack);
  assign e_rx   = ev_rx     & ~(ev_stop | ev_wstart | ev_rstart | ev_nack | ev_rdreq);

  always_comb begin
    st_nx  = st;
    act    = X_NONE;
    act_rd = 1'b0;
    if (e_stop) begin
      st_nx = S_IDLE;
      if (st == S_WDATA) begin
        act = flush_action(int'(cnt));
      end else if (st == S_RXBYTE) begin
        act    = X_QUICK;
        act_rd = 1'b1;
      end
    end else if (e_ws) begin
      st_nx = (st == S_IDLE) ? S_WDATA : S_FAULT;
    end else if (e_rs) begin
      if (st == S_IDLE) begin
        st_nx = S_RXBYTE;
      end else if (st == S_WDATA && cnt != '0) begin
        st_nx = S_RDATA;
        act   = turn_action(int'(cnt));
      end else begin
        st_nx = S_FAULT;
      end
    end else if (e_nk) begin
      if (st == S_RDATA)      st_nx = S_DONE;
      else if (st != S_DONE)  st_nx = S_FAULT;
    end else if (e_rq) begin
      if (st == S_RXBYTE)     st_nx = S_DONE;
      else if (st != S_RDATA) st_nx = S_FAULT;
    end
  end

  assign rx_req  = e_rq & (st == S_RXBYTE);
  assign rd_req  = e_rq & (st == S_RDATA);
  assign tx_byte = (rx_req | rd_req) ? be_rdata : 8'h00;

  assign append  = e_rx & (st == S_WDATA);
  assign cnt_clr = e_stop | (e_rs & (st == S_WDATA));
  assign idx_inc = rd_req;
  assign ovf_clr = e_ws & (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      quick_pulse <= 1'b0;
      quick_rd    <= 1'b0;
      send_pulse  <= 1'b0;
      wr_pulse    <= 1'b0;
      wr_len      <= '0;
    end else begin
      st          <= st_nx;
      quick_pulse <= (act == X_QUICK);
      send_pulse  <= (act == X_SEND);
      wr_pulse    <= (act == X_WRITE);
      if (act == X_QUICK) quick_rd <= act_rd;
      if (act == X_WRITE) wr_len   <= LEN_W'(cnt - 1'b1);
    end
  end

endmodule

// File: rtl/smbus_txn_decoder.sv
`timescale 1ns/1ps
module smbus_txn_decoder
  import smbt_pkg::*;
#(
  parameter int DEPTH = 34,
  parameter int IDX_W = 8,
  localparam int LEN_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_wstart,
  input  logic                   ev_rstart,
  input  logic                   ev_stop,
  input  logic                   ev_nack,
  input  logic                   ev_rx,
  input  logic [7:0]             rx_byte,
  input  logic                   ev_rdreq,
  input  logic [7:0]             be_rdata,
  output logic [7:0]             tx_byte,
  output logic                   quick_pulse,
  output logic                   quick_rd,
  output logic                   send_pulse,
  output logic                   wr_pulse,
  output logic [LEN_W-1:0]       wr_len,
  output logic [8*(DEPTH-1)-1:0] wr_payload,
  output logic [7:0]             cmd,
  output logic                   rx_req,
  output logic                   rd_req,
  output logic [IDX_W-1:0]       rd_idx,
  output logic                   overflow,
  output logic                   fault
);

  st_t              st;
  logic [IDX_W-1:0] cnt;
  logic             e_ws, e_stop;
  logic             append, cnt_clr, idx_inc, ovf_clr;

  smbt_fsm #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ev_wstart(ev_wstart), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
    .ev_nack(ev_nack), .ev_rx(ev_rx), .ev_rdreq(ev_rdreq),
    .cnt(cnt), .be_rdata(be_rdata),
    .st(st), .e_ws(e_ws), .e_stop(e_stop),
    .append(append), .cnt_clr(cnt_clr), .idx_inc(idx_inc), .ovf_clr(ovf_clr),
    .tx_byte(tx_byte), .rx_req(rx_req), .rd_req(rd_req),
    .quick_pulse(quick_pulse), .quick_rd(quick_rd),
    .send_pulse(send_pulse), .wr_pulse(wr_pulse), .wr_len(wr_len)
  );

  smbt_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .append(append), .cnt_clr(cnt_clr), .idx_inc(idx_inc), .ovf_clr(ovf_clr),
    .rx_byte(rx_byte),
    .cnt(cnt), .overflow(overflow), .cmd(cmd), .payload(wr_payload)
  );

  assign rd_idx = cnt;
  assign fault  = (st == S_FAULT);

endmodule

// File: rtl/smbt_chk.sv
`timescale 1ns/1ps
module smbt_chk
  import smbt_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input st_t              st,
  input logic [IDX_W-1:0] cnt,
  input logic             e_ws,
  input logic             e_stop,
  input logic             ev_rdreq,
  input logic             rx_req,
  input logic             rd_req,
  input logic [IDX_W-1:0] rd_idx,
  input logic [7:0]       tx_byte,
  input logic             quick_pulse,
  input logic             quick_rd,
  input logic             send_pulse,
  input logic             wr_pulse,
  input logic             overflow,
  input logic             fault
);

  a_r2_bad_wstart_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (e_ws && st != S_IDLE) |=> fault);

  a_r3_empty_write_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (e_stop && st == S_WDATA && cnt == '0) |=> (quick_pulse && !quick_rd));

  a_r3_read_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (e_stop && st == S_RXBYTE) |=> (quick_pulse && quick_rd));

  a_r5_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({quick_pulse, send_pulse, wr_pulse}));

  a_r7_rxbyte_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |=> (st == S_DONE));

  a_r8_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(e_ws && st == S_IDLE)) |=> overflow);

  a_r12_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !e_stop) |=> fault);

  a_r12_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    e_stop |=> (st == S_IDLE));

  a_r12_stray_request_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rdreq && !rx_req && !rd_req) |-> (tx_byte == 8'h00));

endmodule

bind smbus_txn_decoder smbt_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .e_ws(e_ws), .e_stop(e_stop),
  .ev_rdreq(ev_rdreq), .rx_req(rx_req), .rd_req(rd_req), .rd_idx(rd_idx),
  .tx_byte(tx_byte), .quick_pulse(quick_pulse), .quick_rd(quick_rd),
  .send_pulse(send_pulse), .wr_pulse(wr_pulse), .overflow(overflow), .fault(fault)
);

// File: tb/smbus_txn_decoder_test.sv
`timescale 1ns/1ps
module smbus_txn_decoder_test;
  localparam int DEPTH = 34;
  localparam int IDX_W = 8;
  localparam int LEN_W = $clog2(DEPTH);

  // Event mask bits used by the bench
  localparam logic [5:0] WS = 6'b000001, RS = 6'b000010, SP = 6'b000100,
                         NK = 6'b001000, RX = 6'b010000, RQ = 6'b100000;
  // Model states
  localparam int M_IDLE = 0, M_WD = 1, M_RB = 2, M_RD = 3, M_DN = 4, M_ERR = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic ev_wstart = 0, ev_rstart = 0, ev_stop = 0, ev_nack = 0, ev_rx = 0, ev_rdreq = 0;
  logic [7:0] rx_byte = 0, be_rdata = 0;
  logic [7:0] tx_byte, cmd;
  logic quick_pulse, quick_rd, send_pulse, wr_pulse, rx_req, rd_req, overflow, fault;
  logic [LEN_W-1:0] wr_len;
  logic [8*(DEPTH-1)-1:0] wr_payload;
  logic [IDX_W-1:0] rd_idx;

  smbus_txn_decoder #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .ev_wstart(ev_wstart), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .ev_nack(ev_nack), .ev_rx(ev_rx), .rx_byte(rx_byte),
    .ev_rdreq(ev_rdreq), .be_rdata(be_rdata), .tx_byte(tx_byte),
    .quick_pulse(quick_pulse), .quick_rd(quick_rd), .send_pulse(send_pulse),
    .wr_pulse(wr_pulse), .wr_len(wr_len), .wr_payload(wr_payload), .cmd(cmd),
    .rx_req(rx_req), .rd_req(rd_req), .rd_idx(rd_idx), .overflow(overflow), .fault(fault)
  );

  int compared = 0, mismatched = 0, ncyc = 0;
  bit finished = 0;
  string scen = "init";

  // Reference model state
  int m_st = M_IDLE, m_cnt = 0, m_ovf = 0;
  int m_buf [DEPTH];
  int p_qp = 0, p_qrd = 0, p_sp = 0, p_wp = 0, p_wlen = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s [%s] at cycle %0d: actual %0h expected %0h", tag, what, scen, ncyc, act, exp);
    end
  endtask

  task automatic flush_write();
    if (m_cnt == 0) begin p_qp = 1; p_qrd = 0; end
    else if (m_cnt == 1) p_sp = 1;
    else begin p_wp = 1; p_wlen = m_cnt - 1; end
  endtask

  task automatic cyc(input logic [5:0] m, input logic [7:0] b);
    int w;
    bit x_rx, x_rd;
    int x_tx;
    @(negedge clk);
    ev_wstart = m[0]; ev_rstart = m[1]; ev_stop = m[2];
    ev_nack = m[3]; ev_rx = m[4]; ev_rdreq = m[5];
    rx_byte = b;
    be_rdata = 8'hC3 ^ 8'(ncyc * 7);
    ncyc++;
    #1;
    // R13 priority: stop, write-start, read-start, nack, byte request, byte received
    if (m[2]) w = 2; else if (m[0]) w = 0; else if (m[1]) w = 1;
    else if (m[3]) w = 3; else if (m[5]) w = 5; else if (m[4]) w = 4; else w = -1;
    x_rx = (w == 5) && (m_st == M_RB);
    x_rd = (w == 5) && (m_st == M_RD);
    x_tx = (x_rx || x_rd) ? int'(be_rdata) : 0;
    chk("R7", "rx_req", int'(rx_req), int'(x_rx));
    chk("R8", "rd_req", int'(rd_req), int'(x_rd));
    chk("R12", "tx_byte", int'(tx_byte), x_tx);
    if (x_rd) chk("R8", "rd_idx", int'(rd_idx), m_cnt);
    chk("R3", "quick_pulse", int'(quick_pulse), p_qp);
    if (p_qp != 0) chk("R3", "quick_rd", int'(quick_rd), p_qrd);
    chk("R4", "send_pulse", int'(send_pulse), p_sp);
    chk("R5", "wr_pulse", int'(wr_pulse), p_wp);
    if (p_wp != 0) begin
      chk("R5", "wr_len", int'(wr_len), p_wlen);
      for (int k = 0; k < DEPTH-1; k++)
        chk("R5", "wr_payload", int'(wr_payload[8*k +: 8]), m_buf[k+1]);
    end
    chk("R10", "cmd", int'(cmd), m_buf[0]);
    chk("R11", "overflow", int'(overflow), m_ovf);
    chk("R12", "fault", int'(fault), int'(m_st == M_ERR));
    // Advance the model by one clock
    p_qp = 0; p_sp = 0; p_wp = 0;
    case (w)
      2: begin
        if (m_st == M_WD) flush_write();
        else if (m_st == M_RB) begin p_qp = 1; p_qrd = 1; end
        m_st = M_IDLE; m_cnt = 0;
      end
      0: if (m_st == M_IDLE) begin m_st = M_WD; m_ovf = 0; end else m_st = M_ERR;
      1: begin
        if (m_st == M_IDLE) m_st = M_RB;
        else if (m_st == M_WD && m_cnt > 0) begin
          if (m_cnt > 1) begin p_wp = 1; p_wlen = m_cnt - 1; end
          m_st = M_RD; m_cnt = 0;
        end else m_st = M_ERR;
      end
      3: if (m_st == M_RD) m_st = M_DN; else if (m_st != M_DN) m_st = M_ERR;
      5: begin
        if (m_st == M_RB) m_st = M_DN;
        else if (m_st == M_RD) m_cnt = (m_cnt + 1) % (1 << IDX_W);
        else m_st = M_ERR;
      end
      4: if (m_st == M_WD) begin
        if (m_cnt < DEPTH) begin m_buf[m_cnt] = int'(b); m_cnt++; end
        else m_ovf = 1;
      end
      default: ;
    endcase
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [5:0]  mk;
    for (int k = 0; k < DEPTH; k++) m_buf[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    scen = "R1 reset";
    chk("R1", "fault", int'(fault), 0);
    chk("R1", "overflow", int'(overflow), 0);
    chk("R1", "pulses", int'({quick_pulse, send_pulse, wr_pulse, rx_req, rd_req}), 0);
    cyc(0, 0);

    scen = "R3 quick write";   cyc(WS, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R3 quick read";    cyc(RS, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R4 send byte";     cyc(WS, 0); cyc(RX, 8'h55); cyc(SP, 0); cyc(0, 0);
    scen = "R5 block write";
    cyc(WS, 0); cyc(RX, 8'h10); cyc(RX, 8'h11); cyc(RX, 8'h12); cyc(RX, 8'h13);
    cyc(SP, 0); cyc(0, 0);
    scen = "R6 R8 R9 read one cmd";
    cyc(WS, 0); cyc(RX, 8'h20); cyc(RS, 0); cyc(RQ, 0); cyc(RQ, 0); cyc(RQ, 0);
    cyc(NK, 0); cyc(NK, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R6 flush then read";
    cyc(WS, 0); cyc(RX, 8'h30); cyc(RX, 8'h31); cyc(RS, 0); cyc(RQ, 0); cyc(RQ, 0);
    cyc(NK, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R7 receive byte";  cyc(RS, 0); cyc(RQ, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R7 second request faults"; cyc(RS, 0); cyc(RQ, 0); cyc(RQ, 0); cyc(0, 0); cyc(SP, 0);
    scen = "R6 empty read-start";
    cyc(WS, 0); cyc(RS, 0); cyc(WS, 0); cyc(RX, 8'h77); cyc(NK, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R9 nack in idle";  cyc(NK, 0); cyc(0, 0); cyc(SP, 0);
    scen = "R2 double start";  cyc(WS, 0); cyc(WS, 0); cyc(0, 0); cyc(SP, 0);
    scen = "R12 stray request"; cyc(RQ, 0); cyc(RQ, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R11 overflow";
    cyc(WS, 0);
    for (int k = 0; k < DEPTH + 3; k++) cyc(RX, 8'(8'h40 + k));
    cyc(SP, 0); cyc(0, 0); cyc(0, 0);
    cyc(WS, 0); cyc(SP, 0); cyc(0, 0);
    scen = "R10 byte ignored in read";
    cyc(WS, 0); cyc(RX, 8'h5A); cyc(RS, 0); cyc(RX, 8'h99); cyc(RQ, 0); cyc(NK, 0);
    cyc(RX, 8'h98); cyc(SP, 0); cyc(RX, 8'h97); cyc(0, 0);
    scen = "R13 coincident strobes";
    cyc(WS | RX, 8'hE1); cyc(SP | RX, 8'hE2); cyc(0, 0);
    cyc(RS, 0); cyc(SP | RQ, 0); cyc(0, 0);
    cyc(WS, 0); cyc(RX, 8'h61); cyc(RS | NK, 0); cyc(NK | RQ, 0); cyc(RQ | RX, 8'h62);
    cyc(WS | RS, 0); cyc(SP | WS, 0); cyc(0, 0);
    scen = "R13 random mix";
    lf = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mk = (lf[2:0] == 3'd6) ? RX : (lf[2:0] == 3'd7) ? 6'b0 : 6'(1 << lf[2:0]);
      if (lf[7:5] == 3'd0) mk = mk | 6'(1 << (lf[10:8] % 6));
      cyc(mk, lf[15:8]);
    end
    cyc(SP, 0); cyc(0, 0); cyc(0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule